// File: doc/BRIEF.md
# Register-File Access Watchpoint

This block watches the register-file traffic of a processor core and raises a one-cycle break request when a programmed access happens. Three byte-wide configuration registers hold the watchpoint settings:

- **Control** holds the break enables, a data qualifier and the top address nibble.
- **Address-low** holds the low address byte.
- **Compare data** holds the data value used by the qualifier.

A monitoring port carries the core's 12-bit register address, the 8-bit data and separate read and write strobes. Each access is compared against the settings in the cycle its strobe is high.

A read-protect input locks the watchpoint. While it is high, the break and qualifier bits cannot be set. Bits that were already set are wiped on the next clock, so a protected part cannot be observed through the watchpoint.

Top module: `wpt_unit`

## Requirements
- R1: After reset, all three configuration registers read 0 and `brk_o` is 0.
- R2: `cfg_sel_i` picks the register for writes and readback: 0 is control, 1 is address-low, 2 is compare data, and 3 writes nothing and reads 0. In the control byte, bit 7 is write-break enable, bit 6 is read-break enable, bit 5 is data qualify, and bits 3:0 are the address high nibble.
- R3: Control bit 4 always reads 0, whatever value is written to it.
- R4: The watched address is {control[3:0], address-low[7:0]}. A break needs all 12 monitored address bits to equal it.
- R5: While `rd_protect_i` is 1, a control write leaves bits 7:5 at 0 and still stores bits 3:0.
- R6: If `rd_protect_i` is 1 at a clock edge, control bits 7:5 are 0 after that edge. From then on, no break is raised.
- R7: With data qualify at 0, an enabled access to the watched address breaks whatever its data value.
- R8: With data qualify at 1, an enabled access breaks only when `mon_data_i` equals the compare-data register.
- R9: Data qualify set with both read and write enables at 0 never causes a break.
- R10: `brk_o` is 1 in the cycle after a qualifying access and 0 otherwise. Back-to-back qualifying accesses give back-to-back break cycles.
- R11: A read strobe breaks only if read-break is enabled, and a write strobe breaks only if write-break is enabled. When both strobes are high together, the access breaks if either enabled type matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Configuration register select |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Readback of the selected register |
| rd_protect_i | input | 1 | Read-protect lock |
| mon_addr_i | input | ADDR_W | Monitored register-file address |
| mon_data_i | input | DATA_W | Monitored read or write data |
| mon_rd_i | input | 1 | Monitored read strobe |
| mon_wr_i | input | 1 | Monitored write strobe |
| brk_o | output | 1 | One-cycle break request |

## Verification
The bench builds the block with its default parameters: a 12-bit address and 8-bit data. With these values the seam between the control nibble and the low address byte is within reach. Addresses that differ only in the upper nibble are driven, as are addresses that differ only in the low byte, so each part of the address compare is tested on its own. The 8-bit data width makes the qualifier testable with complementary patterns (0xA5 against 0x5A). It also makes protect-lock readback exact for every control bit.

// File: rtl/wpt_pkg.sv
package wpt_pkg;
  localparam int unsigned CFG_W    = 8;
  localparam int unsigned WR_EN_B  = 7;
  localparam int unsigned RD_EN_B  = 6;
  localparam int unsigned DQ_B     = 5;
  localparam int unsigned RSVD_B   = 4;
  localparam int unsigned NIB_W    = 4;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_ALO  = 2'd1,
    SEL_CMP  = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/wpt_cfg.sv
module wpt_cfg
  import wpt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       sel_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic             protect_i,
  output logic [CFG_W-1:0] ctrl_o,
  output logic [CFG_W-1:0] alo_o,
  output logic [CFG_W-1:0] cmp_o,
  output logic [CFG_W-1:0] rdata_o
);
  logic [CFG_W-1:0] ctrl_q, alo_q, cmp_q, ctrl_d;
  cfg_sel_e sel;

  assign sel = cfg_sel_e'(sel_i);

  always_comb begin
    ctrl_d = ctrl_q;
    if (we_i && sel == SEL_CTRL) ctrl_d = wdata_i;
    ctrl_d[RSVD_B] = 1'b0;
    // lock wins over any write and wipes bits already set
    if (protect_i) begin
      ctrl_d[WR_EN_B] = 1'b0;
      ctrl_d[RD_EN_B] = 1'b0;
      ctrl_d[DQ_B]    = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      alo_q  <= '0;
      cmp_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      if (we_i && sel == SEL_ALO) alo_q <= wdata_i;
      if (we_i && sel == SEL_CMP) cmp_q <= wdata_i;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL: rdata_o = ctrl_q;
      SEL_ALO:  rdata_o = alo_q;
      SEL_CMP:  rdata_o = cmp_q;
      default:  rdata_o = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign alo_o  = alo_q;
  assign cmp_o  = cmp_q;
endmodule

// File: rtl/wpt_match.sv
module wpt_match #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic              dq_i,
  input  logic [HI_W-1:0]   hi_i,
  input  logic [DATA_W-1:0] lo_i,
  input  logic [DATA_W-1:0] cmp_i,
  input  logic [ADDR_W-1:0] mon_addr_i,
  input  logic [DATA_W-1:0] mon_data_i,
  input  logic              mon_rd_i,
  input  logic              mon_wr_i,
  output logic              brk_o
);
  logic addr_hit, data_ok, type_hit, hit, brk_q;

  assign addr_hit = (mon_addr_i == {hi_i, lo_i});
  assign data_ok  = !dq_i || (mon_data_i == cmp_i);
  assign type_hit = (mon_rd_i && rd_en_i) || (mon_wr_i && wr_en_i);
  assign hit      = addr_hit && data_ok && type_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) brk_q <= 1'b0;
    else         brk_q <= hit;
  end

  assign brk_o = brk_q;
endmodule

// File: rtl/wpt_unit.sv
module wpt_unit
  import wpt_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [7:0]        cfg_wdata_i,
  output logic [7:0]        cfg_rdata_o,
  input  logic              rd_protect_i,
  input  logic [ADDR_W-1:0] mon_addr_i,
  input  logic [DATA_W-1:0] mon_data_i,
  input  logic              mon_rd_i,
  input  logic              mon_wr_i,
  output logic              brk_o
);
  localparam int unsigned HI_W = ADDR_W - DATA_W;

  logic [CFG_W-1:0] ctrl_q, alo_q, cmp_q;

  wpt_cfg u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .sel_i     (cfg_sel_i),
    .wdata_i   (cfg_wdata_i),
    .protect_i (rd_protect_i),
    .ctrl_o    (ctrl_q),
    .alo_o     (alo_q),
    .cmp_o     (cmp_q),
    .rdata_o   (cfg_rdata_o)
  );

  wpt_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (ctrl_q[WR_EN_B]),
    .rd_en_i    (ctrl_q[RD_EN_B]),
    .dq_i       (ctrl_q[DQ_B]),
    .hi_i       (ctrl_q[HI_W-1:0]),
    .lo_i       (alo_q[DATA_W-1:0]),
    .cmp_i      (cmp_q[DATA_W-1:0]),
    .mon_addr_i (mon_addr_i),
    .mon_data_i (mon_data_i),
    .mon_rd_i   (mon_rd_i),
    .mon_wr_i   (mon_wr_i),
    .brk_o      (brk_o)
  );
endmodule

// File: rtl/wpt_unit_chk.sv
module wpt_unit_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        cfg_sel_i,
  input logic [7:0]        cfg_rdata_o,
  input logic              rd_protect_i,
  input logic [ADDR_W-1:0] mon_addr_i,
  input logic [DATA_W-1:0] mon_data_i,
  input logic              mon_rd_i,
  input logic              mon_wr_i,
  input logic              brk_o,
  input logic [7:0]        ctrl_q,
  input logic [7:0]        alo_q,
  input logic [7:0]        cmp_q
);
  localparam int unsigned HI_W = ADDR_W - DATA_W;

  p_rsvd_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_sel_i == 2'd0) |-> !cfg_rdata_o[4]);

  p_lock_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_protect_i) |-> (ctrl_q[7:5] == 3'b000));

  p_brk_addr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o |-> ($past(mon_addr_i) == {$past(ctrl_q[HI_W-1:0]), $past(alo_q[DATA_W-1:0])}));

  p_brk_access_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o |-> $past(mon_rd_i || mon_wr_i));

  p_no_dq_alone_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o |-> $past(ctrl_q[7] || ctrl_q[6]));

  p_dq_data_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o |-> (!$past(ctrl_q[5]) || ($past(mon_data_i) == $past(cmp_q[DATA_W-1:0]))));

  p_type_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o |-> $past((mon_rd_i && ctrl_q[6]) || (mon_wr_i && ctrl_q[7])));
endmodule

bind wpt_unit wpt_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_sel_i    (cfg_sel_i),
  .cfg_rdata_o  (cfg_rdata_o),
  .rd_protect_i (rd_protect_i),
  .mon_addr_i   (mon_addr_i),
  .mon_data_i   (mon_data_i),
  .mon_rd_i     (mon_rd_i),
  .mon_wr_i     (mon_wr_i),
  .brk_o        (brk_o),
  .ctrl_q       (ctrl_q),
  .alo_q        (alo_q),
  .cmp_q        (cmp_q)
);

// File: tb/wpt_unit_bench.sv
`timescale 1ns/1ps
module wpt_unit_bench;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [1:0]        cfg_sel = 2'd0;
  logic [7:0]        cfg_wdata = '0;
  logic [7:0]        cfg_rdata;
  logic              protect = 1'b0;
  logic [ADDR_W-1:0] mon_addr = '0;
  logic [DATA_W-1:0] mon_data = '0;
  logic              mon_rd = 1'b0;
  logic              mon_wr = 1'b0;
  logic              brk;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  bit    exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  wpt_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wpt_unit (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .cfg_we_i     (cfg_we),
    .cfg_sel_i    (cfg_sel),
    .cfg_wdata_i  (cfg_wdata),
    .cfg_rdata_o  (cfg_rdata),
    .rd_protect_i (protect),
    .mon_addr_i   (mon_addr),
    .mon_data_i   (mon_data),
    .mon_rd_i     (mon_rd),
    .mon_wr_i     (mon_wr),
    .brk_o        (brk)
  );

  // monitor: one expected break value per cycle after each driven cycle
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      bit e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_run++;
      if (brk !== e) begin
        n_fail++;
        $display("FAIL %s: brk_o=%0b expected %0b", t, brk, e);
      end
    end
  end

  task automatic cfg_write(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_check(input logic [1:0] sel, input logic [7:0] e, input string t);
    @(negedge clk);
    cfg_sel = sel;
    #1;
    n_run++;
    if (cfg_rdata !== e) begin
      n_fail++;
      $display("FAIL %s: rdata=%02h expected %02h", t, cfg_rdata, e);
    end
  endtask

  // drive one access; optionally one idle cycle that must not break
  task automatic access(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                        input logic rd, input logic wr, input bit e,
                        input string t, input bit idle);
    @(negedge clk);
    mon_addr = a; mon_data = d; mon_rd = rd; mon_wr = wr;
    exp_q.push_back(e); tag_q.push_back(t);
    if (idle) begin
      @(negedge clk);
      mon_rd = 1'b0; mon_wr = 1'b0;
      exp_q.push_back(1'b0); tag_q.push_back({t, " idle R10"});
    end
  endtask

  task automatic quiet;
    @(negedge clk);
    mon_rd = 1'b0; mon_wr = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #1;
    n_run++;
    if (brk !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: brk_o=%0b expected 0", brk);
    end
    cfg_check(2'd0, 8'h00, "R1 ctrl");
    cfg_check(2'd1, 8'h00, "R1 alo");
    cfg_check(2'd2, 8'h00, "R1 cmp");

    // R2/R3 layout and readback
    cfg_write(2'd0, 8'hFF);
    cfg_check(2'd0, 8'hEF, "R3 reserved bit");
    cfg_write(2'd1, 8'h34);
    cfg_check(2'd1, 8'h34, "R2 alo");
    cfg_write(2'd2, 8'hA5);
    cfg_check(2'd2, 8'hA5, "R2 cmp");
    cfg_write(2'd3, 8'h77);
    cfg_check(2'd3, 8'h00, "R2 sel3");
    cfg_check(2'd1, 8'h34, "R2 sel3 no write");

    // R11 read-only enable, R4 address compare
    cfg_write(2'd0, 8'h41);
    cfg_write(2'd1, 8'h23);
    access(12'h123, 8'h00, 1, 0, 1, "R11 read hit", 1);
    access(12'h123, 8'h00, 0, 1, 0, "R11 write ignored", 1);
    access(12'h124, 8'h00, 1, 0, 0, "R4 low byte miss", 1);
    access(12'h023, 8'h00, 1, 0, 0, "R4 high nibble miss", 1);
    access(12'h123, 8'h00, 1, 1, 1, "R11 rd+wr", 1);
    quiet();

    // R11 write-only enable
    cfg_write(2'd0, 8'h81);
    access(12'h123, 8'h11, 0, 1, 1, "R11 write hit", 1);
    access(12'h123, 8'h11, 1, 0, 0, "R11 read ignored", 1);
    quiet();

    // R8 data qualify
    cfg_write(2'd0, 8'hE1);
    access(12'h123, 8'hA5, 1, 0, 1, "R8 data equal", 1);
    access(12'h123, 8'h5A, 0, 1, 0, "R8 data differ", 1);
    quiet();

    // R9 qualifier alone
    cfg_write(2'd0, 8'h21);
    access(12'h123, 8'hA5, 1, 0, 0, "R9 qualify alone rd", 1);
    access(12'h123, 8'hA5, 0, 1, 0, "R9 qualify alone wr", 1);
    quiet();

    // R7 no qualifier, R10 back-to-back
    cfg_write(2'd0, 8'hC1);
    access(12'h123, 8'h00, 1, 0, 1, "R7 any data", 1);
    access(12'h123, 8'h3C, 1, 0, 1, "R10 back-to-back 1", 0);
    access(12'h123, 8'hC3, 0, 1, 1, "R10 back-to-back 2", 1);
    quiet();

    // R6 lock wipes set bits
    @(negedge clk);
    protect = 1'b1;
    @(negedge clk);
    cfg_check(2'd0, 8'h01, "R6 bits wiped");
    access(12'h123, 8'h00, 1, 1, 0, "R6 no break", 1);
    quiet();

    // R5 write under lock
    cfg_write(2'd0, 8'hE7);
    cfg_check(2'd0, 8'h07, "R5 write under lock");

    @(negedge clk);
    protect = 1'b0;
    cfg_write(2'd0, 8'hC3);
    cfg_check(2'd0, 8'hC3, "R5 unlocked write");
    access(12'h323, 8'h00, 1, 0, 1, "R4 new nibble hit", 1);
    quiet();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule